// File: doc/BRIEF.md
# Blocking Write-Back Data Cache Controller

This block is the control and storage for a direct-mapped data cache that sits between a processor load/store port and a slower block-wide memory. It holds 1024 blocks of four 32-bit words (16 KB) addressed by 32-bit byte addresses. Every block keeps a valid flag and a dirty flag. Stores that hit are kept in the cache and mark the block dirty. Memory sees a block only when a dirty block is evicted or when a missing block is fetched.

The processor raises a request with a read/write flag, an address and, for stores, a word of data. It keeps the request steady until the single-cycle ready pulse arrives, and drops it at that point. The controller compares the stored tag. On a miss it first writes back a dirty victim, then fetches the wanted block over the 128-bit memory port, which may take any number of cycles per transfer. It then repeats the tag comparison, which now hits, and completes the access. Stores that miss are therefore allocated first and merged afterwards. Only one access is in flight at a time, and the processor waits for the whole of it.

Top module: `wbcache_ctrl`

## Requirements
- R1: While reset is high and in the cycle after it falls, cpu_ready and mem_valid are 0. Every block starts invalid, so the first access to any index fetches its block from memory.
- R2: The address decodes as tag = bits 31..14, index = bits 13..4 and word = bits 3..2. Bits 1..0 have no effect. Two addresses that differ only in the tag share one block, and addresses with different indexes never disturb each other.
- R3: On a read hit, no memory request is made. cpu_ready is high in the cycle after the first rising edge that follows the accepting edge, and cpu_rdata then holds the addressed word.
- R4: A write hit makes no memory request. It replaces only the addressed word in the cached block and marks the block dirty, and a later read of that word returns the stored value.
- R5: On a miss, the block is fetched with one request that has mem_rw = 0 (read) and mem_addr = {new tag, index, 4'b0000}. The data returned on mem_rdata while mem_ready is high fills the block.
- R6: If the block being replaced is valid and dirty, a write request is made first. It has mem_rw = 1, mem_addr = {old tag, index, 4'b0000} and mem_wdata = the whole old block. The fetch of R5 is issued in the cycle directly after that write is acknowledged.
- R7: A memory request holds mem_valid, mem_rw, mem_addr and mem_wdata steady until the cycle in which mem_ready is high. A transfer completes at that rising edge.
- R8: A filled block is valid and clean. Replacing it later causes no write-back. After a fill, cpu_ready is high in the cycle after the first rising edge that follows the fill edge, and mem_valid is 0 by then.
- R9: A write miss fetches the block first. It then merges the store word into the block and marks the block dirty, so that a later eviction writes the merged block back.
- R10: cpu_ready is a one-cycle pulse. It is never high while a memory request is outstanding, and the access is never acknowledged before all of its memory transfers are done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_valid | input | 1 | Processor request present, held until cpu_ready |
| cpu_rw | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 32 | Byte address |
| cpu_wdata | input | 32 | Store data |
| cpu_rdata | output | 32 | Load data, valid with cpu_ready on a load |
| cpu_ready | output | 1 | One-cycle completion pulse |
| mem_valid | output | 1 | Memory request present |
| mem_rw | output | 1 | 1 = block write, 0 = block read |
| mem_addr | output | 32 | Block-aligned memory address |
| mem_wdata | output | 128 | Block written back |
| mem_rdata | input | 128 | Block returned, sampled with mem_ready |
| mem_ready | input | 1 | Memory acknowledges the current request |

## Verification
Two events can fall in the same cycle. The first pair is the fill write into the tag and data arrays and the re-read of that same index for the repeated compare. The second pair is the acknowledgement of a write-back and the issue of the fetch that follows it. Every miss provokes the first pair, and dirty evictions provoke the second, with memory latencies of one to three cycles. The first pair is judged by the retried compare hitting at once, returning fill data or the merged store word, and making no second fetch. The second pair is judged per clock: the read request must appear in the very cycle after the write acknowledgement, with the new tag and the same index.

// File: rtl/wbc_pkg.sv
package wbc_pkg;
  // Controller state, binary encoded in a 2-bit register.
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CMP   = 2'd1,
    ST_WB    = 2'd2,
    ST_ALLOC = 2'd3
  } wbc_state_e;
endpackage

// File: rtl/wbc_tag_store.sv
module wbc_tag_store #(
  parameter int TAG_W = 18,
  parameter int IDX_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] rd_idx,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic             wr_valid,
  input  logic             wr_dirty,
  output logic [TAG_W-1:0] q_tag,
  output logic             q_valid,
  output logic             q_dirty
);
  localparam int DEPTH = 1 << IDX_W;

  logic [TAG_W-1:0] tag_mem [DEPTH];
  logic [DEPTH-1:0] valid_r;
  logic [DEPTH-1:0] dirty_r;
  logic             same_slot;

  assign same_slot = wr_en && (wr_idx == rd_idx);

  // Tag RAM: no reset, registered read, new data forwarded on a same-slot write.
  always_ff @(posedge clk) begin
    if (wr_en) tag_mem[wr_idx] <= wr_tag;
    if (same_slot) q_tag <= wr_tag;
    else           q_tag <= tag_mem[rd_idx];
  end

  // State flags live in flops so that reset can clear every block.
  always_ff @(posedge clk) begin
    if (rst) begin
      valid_r <= '0;
      dirty_r <= '0;
      q_valid <= 1'b0;
      q_dirty <= 1'b0;
    end else begin
      if (wr_en) begin
        valid_r[wr_idx] <= wr_valid;
        dirty_r[wr_idx] <= wr_dirty;
      end
      if (same_slot) begin
        q_valid <= wr_valid;
        q_dirty <= wr_dirty;
      end else begin
        q_valid <= valid_r[rd_idx];
        q_dirty <= dirty_r[rd_idx];
      end
    end
  end
endmodule

// File: rtl/wbc_data_store.sv
module wbc_data_store #(
  parameter int BLK_W = 128,
  parameter int IDX_W = 10
) (
  input  logic             clk,
  input  logic [IDX_W-1:0] rd_idx,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [BLK_W-1:0] wr_data,
  output logic [BLK_W-1:0] q_data
);
  localparam int DEPTH = 1 << IDX_W;

  logic [BLK_W-1:0] blk_mem [DEPTH];

  // Single write port, registered read, write-first on a matching slot.
  always_ff @(posedge clk) begin
    if (wr_en) blk_mem[wr_idx] <= wr_data;
    if (wr_en && (wr_idx == rd_idx)) q_data <= wr_data;
    else                             q_data <= blk_mem[rd_idx];
  end
endmodule

// File: rtl/wbc_fsm.sv
module wbc_fsm
  import wbc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int WORD_W = 32,
  parameter int WORDS  = 4,
  parameter int IDX_W  = 10,
  parameter int TAG_W  = 18,
  parameter int OFF_W  = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cpu_valid,
  input  logic                    cpu_rw,
  input  logic [ADDR_W-1:0]       cpu_addr,
  input  logic [WORD_W-1:0]       cpu_wdata,
  output logic [WORD_W-1:0]       cpu_rdata,
  output logic                    cpu_ready,
  output logic                    mem_valid,
  output logic                    mem_rw,
  output logic [ADDR_W-1:0]       mem_addr,
  output logic [WORD_W*WORDS-1:0] mem_wdata,
  input  logic [WORD_W*WORDS-1:0] mem_rdata,
  input  logic                    mem_ready,
  output logic [IDX_W-1:0]        rd_idx,
  input  logic [TAG_W-1:0]        q_tag,
  input  logic                    q_valid,
  input  logic                    q_dirty,
  input  logic [WORD_W*WORDS-1:0] q_data,
  output logic                    tag_we,
  output logic [IDX_W-1:0]        wr_idx,
  output logic [TAG_W-1:0]        wr_tag,
  output logic                    wr_valid,
  output logic                    wr_dirty,
  output logic                    data_we,
  output logic [WORD_W*WORDS-1:0] wr_data
);
  localparam int BLK_W  = WORD_W * WORDS;
  localparam int WSEL_W = (WORDS > 1) ? $clog2(WORDS) : 1;
  localparam int BSEL_W = $clog2(WORD_W / 8);

  wbc_state_e state;

  logic [ADDR_W-1:0] req_addr;
  logic              req_rw;
  logic [WORD_W-1:0] req_wdata;

  logic [IDX_W-1:0]  req_idx;
  logic [TAG_W-1:0]  req_tag;
  logic [WSEL_W-1:0] req_wsel;
  logic              hit;
  logic              fill_done;
  logic              store_hit;
  logic [BLK_W-1:0]  merged;
  logic [WORD_W-1:0] lane [WORDS];
  logic              unused_bits;

  assign req_idx     = req_addr[OFF_W +: IDX_W];
  assign req_tag     = req_addr[ADDR_W-1 -: TAG_W];
  assign req_wsel    = req_addr[BSEL_W +: WSEL_W];
  assign unused_bits = ^req_addr[BSEL_W-1:0];

  assign hit       = q_valid && (q_tag == req_tag);
  assign fill_done = (state == ST_ALLOC) && mem_ready;
  assign store_hit = (state == ST_CMP) && hit && req_rw;

  // One lane per word: read mux source and store merge.
  for (genvar w = 0; w < WORDS; w++) begin : g_lane
    assign lane[w] = q_data[w*WORD_W +: WORD_W];
    assign merged[w*WORD_W +: WORD_W] =
      (req_wsel == WSEL_W'(w)) ? req_wdata : q_data[w*WORD_W +: WORD_W];
  end

  // Array read address follows the incoming request while idle.
  assign rd_idx = (state == ST_IDLE) ? cpu_addr[OFF_W +: IDX_W] : req_idx;

  // Array writes: store hit merges a word, fill installs a clean block.
  always_comb begin
    tag_we   = store_hit || fill_done;
    data_we  = store_hit || fill_done;
    wr_idx   = req_idx;
    wr_tag   = req_tag;
    wr_valid = 1'b1;
    wr_dirty = store_hit;
    wr_data  = fill_done ? mem_rdata : merged;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      req_addr  <= '0;
      req_rw    <= 1'b0;
      req_wdata <= '0;
      cpu_ready <= 1'b0;
      cpu_rdata <= '0;
      mem_valid <= 1'b0;
      mem_rw    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else begin
      cpu_ready <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (cpu_valid) begin
            req_addr  <= cpu_addr;
            req_rw    <= cpu_rw;
            req_wdata <= cpu_wdata;
            state     <= ST_CMP;
          end
        end
        ST_CMP: begin
          if (hit) begin
            cpu_ready <= 1'b1;
            if (!req_rw) cpu_rdata <= lane[req_wsel];
            state <= ST_IDLE;
          end else if (q_valid && q_dirty) begin
            mem_valid <= 1'b1;
            mem_rw    <= 1'b1;
            mem_addr  <= {q_tag, req_idx, {OFF_W{1'b0}}};
            mem_wdata <= q_data;
            state     <= ST_WB;
          end else begin
            mem_valid <= 1'b1;
            mem_rw    <= 1'b0;
            mem_addr  <= {req_tag, req_idx, {OFF_W{1'b0}}};
            state     <= ST_ALLOC;
          end
        end
        ST_WB: begin
          if (mem_ready) begin
            mem_rw   <= 1'b0;
            mem_addr <= {req_tag, req_idx, {OFF_W{1'b0}}};
            state    <= ST_ALLOC;
          end
        end
        ST_ALLOC: begin
          if (mem_ready) begin
            mem_valid <= 1'b0;
            state     <= ST_CMP;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/wbcache_ctrl.sv
module wbcache_ctrl #(
  parameter int ADDR_W = 32,
  parameter int WORD_W = 32,
  parameter int WORDS  = 4,
  parameter int BLOCKS = 1024
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cpu_valid,
  input  logic                    cpu_rw,
  input  logic [ADDR_W-1:0]       cpu_addr,
  input  logic [WORD_W-1:0]       cpu_wdata,
  output logic [WORD_W-1:0]       cpu_rdata,
  output logic                    cpu_ready,
  output logic                    mem_valid,
  output logic                    mem_rw,
  output logic [ADDR_W-1:0]       mem_addr,
  output logic [WORD_W*WORDS-1:0] mem_wdata,
  input  logic [WORD_W*WORDS-1:0] mem_rdata,
  input  logic                    mem_ready
);
  localparam int BLK_W = WORD_W * WORDS;
  localparam int OFF_W = $clog2(BLK_W / 8);
  localparam int IDX_W = $clog2(BLOCKS);
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W;

  logic [IDX_W-1:0] rd_idx;
  logic [TAG_W-1:0] q_tag;
  logic             q_valid;
  logic             q_dirty;
  logic [BLK_W-1:0] q_data;
  logic             tag_we;
  logic             data_we;
  logic [IDX_W-1:0] wr_idx;
  logic [TAG_W-1:0] wr_tag;
  logic             wr_valid;
  logic             wr_dirty;
  logic [BLK_W-1:0] wr_data;

  wbc_fsm #(
    .ADDR_W(ADDR_W), .WORD_W(WORD_W), .WORDS(WORDS),
    .IDX_W(IDX_W), .TAG_W(TAG_W), .OFF_W(OFF_W)
  ) u_fsm (
    .clk(clk), .rst(rst),
    .cpu_valid(cpu_valid), .cpu_rw(cpu_rw), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready),
    .mem_valid(mem_valid), .mem_rw(mem_rw), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
    .rd_idx(rd_idx), .q_tag(q_tag), .q_valid(q_valid), .q_dirty(q_dirty),
    .q_data(q_data), .tag_we(tag_we), .wr_idx(wr_idx), .wr_tag(wr_tag),
    .wr_valid(wr_valid), .wr_dirty(wr_dirty), .data_we(data_we),
    .wr_data(wr_data)
  );

  wbc_tag_store #(.TAG_W(TAG_W), .IDX_W(IDX_W)) u_tags (
    .clk(clk), .rst(rst), .rd_idx(rd_idx), .wr_en(tag_we), .wr_idx(wr_idx),
    .wr_tag(wr_tag), .wr_valid(wr_valid), .wr_dirty(wr_dirty),
    .q_tag(q_tag), .q_valid(q_valid), .q_dirty(q_dirty)
  );

  wbc_data_store #(.BLK_W(BLK_W), .IDX_W(IDX_W)) u_data (
    .clk(clk), .rd_idx(rd_idx), .wr_en(data_we), .wr_idx(wr_idx),
    .wr_data(wr_data), .q_data(q_data)
  );
endmodule

// File: rtl/wbcache_ctrl_chk.sv
module wbcache_ctrl_chk #(
  parameter int ADDR_W = 32,
  parameter int WORD_W = 32,
  parameter int WORDS  = 4,
  parameter int BLOCKS = 1024
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    cpu_ready,
  input logic                    mem_valid,
  input logic                    mem_rw,
  input logic [ADDR_W-1:0]       mem_addr,
  input logic [WORD_W*WORDS-1:0] mem_wdata,
  input logic                    mem_ready
);
  localparam int OFF_W = $clog2(WORD_W * WORDS / 8);
  localparam int IDX_W = $clog2(BLOCKS);

  AST_RESET_QUIET: assert property (@(posedge clk) rst |=> (!cpu_ready && !mem_valid)); // R1

  AST_BLOCK_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    mem_valid |-> (mem_addr[OFF_W-1:0] == '0)); // R5

  AST_FETCH_AFTER_WB: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && mem_ready && mem_rw) |=>
      (mem_valid && !mem_rw && (mem_addr[OFF_W +: IDX_W] == $past(mem_addr[OFF_W +: IDX_W])))); // R6

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && !mem_ready) |=>
      (mem_valid && $stable(mem_rw) && $stable(mem_addr) && $stable(mem_wdata))); // R7

  AST_FILL_COMPLETES: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && mem_ready && !mem_rw) |=> (!mem_valid ##1 cpu_ready)); // R8

  AST_READY_PULSE: assert property (@(posedge clk) disable iff (rst)
    cpu_ready |=> !cpu_ready); // R10

  AST_NO_EARLY_READY: assert property (@(posedge clk) disable iff (rst)
    mem_valid |-> !cpu_ready); // R10
endmodule

bind wbcache_ctrl wbcache_ctrl_chk #(
  .ADDR_W(ADDR_W), .WORD_W(WORD_W), .WORDS(WORDS), .BLOCKS(BLOCKS)
) u_chk (
  .clk(clk), .rst(rst), .cpu_ready(cpu_ready), .mem_valid(mem_valid),
  .mem_rw(mem_rw), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
  .mem_ready(mem_ready)
);

// File: tb/wbcache_ctrl_bench.sv
`timescale 1ns/1ps
module wbcache_ctrl_bench;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         cpu_valid = 1'b0;
  logic         cpu_rw = 1'b0;
  logic [31:0]  cpu_addr = '0;
  logic [31:0]  cpu_wdata = '0;
  logic [31:0]  cpu_rdata;
  logic         cpu_ready;
  logic         mem_valid;
  logic         mem_rw;
  logic [31:0]  mem_addr;
  logic [127:0] mem_wdata;
  logic [127:0] mem_rdata = '0;
  logic         mem_ready = 1'b0;

  always #2 clk = ~clk;

  wbcache_ctrl u_wbcache_ctrl (
    .clk(clk), .rst(rst), .cpu_valid(cpu_valid), .cpu_rw(cpu_rw),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .cpu_ready(cpu_ready), .mem_valid(mem_valid), .mem_rw(mem_rw),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_ready(mem_ready)
  );

  typedef struct { bit we; logic [31:0] addr; logic [31:0] wd; string lbl; } req_t;
  typedef struct { bit rw; logic [31:0] addr; logic [127:0] data; } op_t;

  req_t reqs[$];
  op_t  ops[$];
  int   n_cmp = 0;
  int   n_bad = 0;

  // Behavioural cache and memory model.
  logic [17:0]  m_tag [1024];
  bit           m_val [1024];
  bit           m_dirty [1024];
  logic [127:0] m_data [1024];
  logic [127:0] mm [int unsigned];

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  function automatic logic [127:0] mem_get(input int unsigned blk);
    logic [127:0] v;
    if (mm.exists(blk)) return mm[blk];
    for (int w = 0; w < 4; w++) v[w*32 +: 32] = (blk * 4 + w) ^ 32'h5A00_0000;
    return v;
  endfunction

  function automatic logic [31:0] mk(input int tg, input int idx, input int wd, input int by);
    return {tg[17:0], idx[9:0], wd[1:0], by[1:0]};
  endfunction

  task automatic add(input bit we, input logic [31:0] a, input logic [31:0] d, input string l);
    req_t r;
    r.we = we; r.addr = a; r.wd = d; r.lbl = l;
    reqs.push_back(r);
  endtask

  // Apply one request to the model; returns the expected load word.
  task automatic model(input req_t r, output logic [31:0] exp_rd);
    int idx, wsel;
    logic [17:0] tg;
    op_t o;
    idx = int'(r.addr[13:4]); tg = r.addr[31:14]; wsel = int'(r.addr[3:2]);
    if (!(m_val[idx] && m_tag[idx] == tg)) begin
      if (m_val[idx] && m_dirty[idx]) begin
        o.rw = 1'b1; o.addr = {m_tag[idx], r.addr[13:4], 4'b0}; o.data = m_data[idx];
        mm[int'(o.addr[31:4])] = m_data[idx];
        ops.push_back(o);
      end
      o.rw = 1'b0; o.addr = {tg, r.addr[13:4], 4'b0};
      o.data = mem_get(int'(o.addr[31:4]));
      ops.push_back(o);
      m_data[idx] = o.data; m_tag[idx] = tg; m_val[idx] = 1'b1; m_dirty[idx] = 1'b0;
    end
    exp_rd = m_data[idx][wsel*32 +: 32];
    if (r.we) begin
      m_data[idx][wsel*32 +: 32] = r.wd;
      m_dirty[idx] = 1'b1;
    end
  endtask

  initial begin
    int cyc = 0;
    bit pending = 0, started = 0, from_hs = 0, prev_mv = 0, mr_drv = 0, prev_cv = 0;
    int since = 0, cnt = 0, lat = 1, opn = 0;
    req_t cur;
    logic [31:0] exp_rd = '0;
    bit exp_rdy, exp_mv;
    logic [31:0] s = 32'h1234_5678;

    for (int i = 0; i < 1024; i++) begin m_val[i] = 0; m_dirty[i] = 0; m_tag[i] = '0; m_data[i] = '0; end

    // Directed sequence.
    add(0, mk(1, 5, 2, 0), 0, "R1 cold miss fetch");
    add(0, mk(1, 5, 2, 3), 0, "R3/R2 read hit, byte bits ignored");
    add(1, mk(1, 5, 1, 0), 32'hCAFE_0001, "R4 write hit");
    add(0, mk(1, 5, 1, 2), 0, "R4 read back stored word");
    add(0, mk(2, 5, 0, 0), 0, "R6 dirty eviction then fetch");
    add(0, mk(1, 5, 1, 0), 0, "R8 clean victim, written data from memory");
    add(1, mk(3, 9, 3, 0), 32'hBEEF_0003, "R9 write miss allocate");
    add(0, mk(3, 9, 3, 0), 0, "R9 merged word reads back");
    add(0, mk(3, 9, 0, 0), 0, "R9 other words from fill");
    add(0, mk(4, 9, 0, 0), 0, "R9 merged block written back");
    add(1, mk(0, 0, 0, 0), 32'h0000_0A0A, "R2 lowest index");
    add(1, mk(262143, 1023, 3, 0), 32'hFFFF_1234, "R2 top tag and index");
    add(0, mk(0, 1023, 3, 0), 0, "R2 same index other tag evicts");
    add(0, mk(0, 0, 0, 1), 0, "R2 index 0 untouched by index 1023");
    add(0, mk(0, 6, 0, 0), 0, "R5 clean fetch");
    add(0, mk(0, 6, 3, 0), 0, "R3 hit after fill");
    for (int i = 0; i < 160; i++) begin
      s ^= s << 13; s ^= s >> 17; s ^= s << 5;
      add(s[8], mk(int'(s[1:0]), (s[4:3] == 2'd0) ? 7 : (s[4:3] == 2'd1) ? 8 : 1023,
                   int'(s[6:5]), int'(s[10:9])), s ^ 32'h0F0F_0000, "R7/R10 mixed traffic");
    end

    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(cpu_ready == 1'b0, "R1", "cpu_ready after reset", cpu_ready, 0);
    chk(mem_valid == 1'b0, "R1", "mem_valid after reset", mem_valid, 0);

    while (1) begin
      @(negedge clk);
      cyc++;
      if (cyc > 100000) begin
        n_cmp++; n_bad++;
        $display("FAIL R10 watchdog expired actual=%0d expected=%0d", cyc, 100000);
        break;
      end
      // Events at the rising edge just passed.
      if (prev_mv && mr_drv) begin
        if (ops.size() > 0) void'(ops.pop_front());
        since = 0; from_hs = 1;
        mem_ready = 1'b0; cnt = 0;
      end else if (started) begin
        since++;
      end
      if (prev_cv && pending && !started) begin
        started = 1; since = 0; from_hs = 0;
      end
      // Per-clock comparison against the model.
      exp_rdy = pending && started && (ops.size() == 0) && (since == 1);
      exp_mv  = started && (ops.size() > 0) && (since >= 1 || from_hs);
      chk(cpu_ready == exp_rdy, "R10", {"cpu_ready: ", cur.lbl}, cpu_ready, exp_rdy);
      chk(mem_valid == exp_mv, "R5/R6", {"mem_valid: ", cur.lbl}, mem_valid, exp_mv);
      if (mem_valid && exp_mv) begin
        chk(mem_rw == ops[0].rw, ops[0].rw ? "R6" : "R5", {"mem_rw: ", cur.lbl}, mem_rw, ops[0].rw);
        chk(mem_addr == ops[0].addr, "R7", {"mem_addr: ", cur.lbl}, mem_addr, ops[0].addr);
        if (ops[0].rw)
          chk(mem_wdata == ops[0].data, "R6", {"mem_wdata: ", cur.lbl}, mem_wdata, ops[0].data);
      end
      if (cpu_ready && exp_rdy) begin
        if (!cur.we) chk(cpu_rdata == exp_rd, "R3", {"cpu_rdata: ", cur.lbl}, cpu_rdata, exp_rd);
        pending = 0; started = 0;
        if (reqs.size() == 0) begin cpu_valid = 1'b0; break; end
      end
      // Processor side.
      if (!pending) begin
        if (reqs.size() > 0) begin
          cur = reqs.pop_front();
          model(cur, exp_rd);
          pending = 1;
          cpu_valid = 1'b1; cpu_rw = cur.we; cpu_addr = cur.addr; cpu_wdata = cur.wd;
        end else begin
          cpu_valid = 1'b0;
        end
      end
      prev_cv = cpu_valid;
      // Memory side: acknowledge after a varying latency.
      if (mem_valid && !mem_ready) begin
        cnt++;
        if (cnt >= lat) begin
          mem_ready = 1'b1;
          mem_rdata = (ops.size() > 0) ? ops[0].data : '0;
          opn++;
          lat = 1 + (opn % 3);
        end
      end
      mr_drv = mem_ready;
      prev_mv = mem_valid;
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule